// File: doc/BRIEF.md
# Dual-Array Flash Command Controller

This block sits between a simple memory bus and two independent behavioural flash arrays: a main array of eight equal sectors and a secondary array of four equal sectors. A cell cannot be written directly. The controller watches the bus writes and decodes an unlock-then-command protocol for each array separately. From that protocol it starts one of three operations on the addressed array: programming a single data unit, erasing one sector, or erasing the whole array. It also supports a bypass mode that shortens later program sequences, and it honours a per-sector protection mask.

Each array has its own sequencer, busy timer and cell storage. One array can be read normally, or given commands, while the other one is working. A shared ready output is low while either array is busy. A read aimed at an array that is busy returns a fixed status word instead of cell contents, and it sets a sticky violation flag. A parameter selects an 8-bit or a 16-bit data bus. The offsets used by the command protocol change with that setting.

Requests use a valid/ready handshake. `req_ready` is tied high, so the block never applies back-pressure, and every cycle in which `req_valid` is high is accepted. A read produces exactly one response on `rsp_valid`/`rsp_data` in the next cycle, and the response cannot be stalled.

Top module: `dual_flash_ctl`

## Requirements
- R1: After reset, `rdy` is 1, `viol` is 0, `rsp_valid` is 0, and every cell of both arrays reads as all ones.
- R2: Address map: `req_addr[12]` selects the array (0 is main, 1 is secondary). For the main array, bits [4:2] give the sector; for the secondary array, bits [3:2] give the sector. Bits [1:0] give the word. A program takes effect only after a fixed sequence of writes, each to the addressed array: 0xAA at command offset A, then 0x55 at command offset B, then 0xA0 at offset A, then the data at the target. In 8-bit mode, A is 0xAAA and B is 0x555. Offsets are compared on bits [11:0].
- R3: A program can only clear bits. The new cell value is the old value AND the written data.
- R4: `rdy` goes low in the cycle after the write that starts an operation is accepted. It stays low for PROG_CYC cycles (default 8) for a program, and for ERASE_CYC cycles (default 32) for either kind of erase.
- R5: Sector erase is AA@A, 55@B, 80@A, AA@A, 55@B, then 0x30 written to any address inside the sector. It sets every cell of that sector to all ones and leaves the other sectors unchanged.
- R6: Bulk erase is the same sequence with 0x10 written at offset A as the last write. It sets every unprotected sector of that array to all ones.
- R7: `prot_mask` bit i protects main sector i, and bit 8+j protects secondary sector j. A program or sector erase aimed at a protected sector is refused: `rdy` stays 1 and the data is unchanged.
- R8: A write that does not fit the expected sequence returns that array to read mode. A write of 0xF0 at any point also returns it to read mode, and it ends bypass mode as well.
- R9: AA@A, 55@B, 0x20@A enters bypass mode. In bypass mode, 0xA0 written anywhere followed by the data programs a cell. Writing 0x90 and then 0x00 leaves bypass mode, after which a lone 0xA0 no longer arms a program.
- R10: A read of an array that is busy returns the status word 0x08 (zero-extended to the bus width) and sets `viol`. `viol` stays set until reset.
- R11: While one array is busy, a read of the other array returns its stored data.
- R12: In 16-bit mode, offset A is 0x555 and offset B is 0x2AA, data is 16 bits wide, and command values are compared zero-extended. A sequence that uses the 8-bit offsets programs nothing.
- R13: `req_ready` is always 1. Each accepted read gives `rsp_valid` high with its data in the following cycle. Cycles without an accepted read give `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, constantly 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | OFF_W+1 (13) | Array select in the top bit, offset below it |
| req_wdata | input | DW (8 or 16) | Write data or command value |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read data or status word |
| prot_mask | input | MAIN_SECT+AUX_SECT (12) | Per-sector protection |
| rdy | output | 1 | 1 when neither array is busy |
| viol | output | 1 | Sticky flag: an array was read while it was busy |

## Verification
A write is accepted at a rising edge. The sequencer decides in that same edge whether the write starts an operation, so `rdy` is already low at the following falling edge. `rdy` returns high exactly PROG_CYC or ERASE_CYC edges after the accepting edge. The bench counts falling edges from the end of the write that starts an operation until `rdy` rises, and compares that count with the parameter. Read data is registered once, so the bench raises a read at a falling edge and samples `rsp_valid` and `rsp_data` at the next falling edge. A refused or ignored operation is judged by sampling `rdy` right after the final write and by reading the target cells back afterwards.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  typedef enum logic [3:0] {
    SQ_READ, SQ_UNL1, SQ_UNL2, SQ_PROG,
    SQ_ER1, SQ_ER2, SQ_ER3,
    SQ_BYP, SQ_BPROG, SQ_BEXIT
  } seq_e;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BULK} op_e;

  localparam logic [7:0] K_UNL_A   = 8'hAA;
  localparam logic [7:0] K_UNL_B   = 8'h55;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_ERASE   = 8'h80;
  localparam logic [7:0] K_SECT    = 8'h30;
  localparam logic [7:0] K_BULK    = 8'h10;
  localparam logic [7:0] K_BYP_IN  = 8'h20;
  localparam logic [7:0] K_BYP_OUT = 8'h90;
  localparam logic [7:0] K_BYP_END = 8'h00;
  localparam logic [7:0] K_RESET   = 8'hF0;
  localparam logic [7:0] K_STATUS  = 8'h08;

endpackage

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
#(
  parameter int NSECT   = 8,
  parameter int SW_BITS = 2,
  parameter int OFF_W   = 12,
  parameter int DW      = 8,
  parameter bit WIDE16  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             busy,
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    wdata,
  input  logic [NSECT-1:0] prot,
  output logic             start,
  output op_e              op
);
  localparam int SB = $clog2(NSECT);
  localparam logic [OFF_W-1:0] OFS_A = WIDE16 ? OFF_W'(12'h555) : OFF_W'(12'hAAA);
  localparam logic [OFF_W-1:0] OFS_B = WIDE16 ? OFF_W'(12'h2AA) : OFF_W'(12'h555);

  seq_e st_q, st_d;
  logic at_a, at_b, hit_prot;

  assign at_a     = (off == OFS_A);
  assign at_b     = (off == OFS_B);
  assign hit_prot = prot[off[SW_BITS +: SB]];

  function automatic logic is_k(input logic [DW-1:0] d, input logic [7:0] k);
    return d == DW'(k);
  endfunction

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    op    = OP_PROG;
    if (wr_en && !busy) begin
      if (is_k(wdata, K_RESET)) begin
        st_d = SQ_READ;
      end else begin
        unique case (st_q)
          SQ_READ: st_d = (at_a && is_k(wdata, K_UNL_A)) ? SQ_UNL1 : SQ_READ;
          SQ_UNL1: st_d = (at_b && is_k(wdata, K_UNL_B)) ? SQ_UNL2 : SQ_READ;
          SQ_UNL2: begin
            if (at_a && is_k(wdata, K_PROG))        st_d = SQ_PROG;
            else if (at_a && is_k(wdata, K_ERASE))  st_d = SQ_ER1;
            else if (at_a && is_k(wdata, K_BYP_IN)) st_d = SQ_BYP;
            else                                    st_d = SQ_READ;
          end
          SQ_PROG: begin
            st_d  = SQ_READ;
            start = !hit_prot;
          end
          SQ_ER1: st_d = (at_a && is_k(wdata, K_UNL_A)) ? SQ_ER2 : SQ_READ;
          SQ_ER2: st_d = (at_b && is_k(wdata, K_UNL_B)) ? SQ_ER3 : SQ_READ;
          SQ_ER3: begin
            st_d = SQ_READ;
            if (is_k(wdata, K_SECT)) begin
              start = !hit_prot;
              op    = OP_SECT;
            end else if (at_a && is_k(wdata, K_BULK)) begin
              start = |(~prot);
              op    = OP_BULK;
            end
          end
          SQ_BYP: begin
            if (is_k(wdata, K_PROG))         st_d = SQ_BPROG;
            else if (is_k(wdata, K_BYP_OUT)) st_d = SQ_BEXIT;
            else                             st_d = SQ_READ;
          end
          SQ_BPROG: begin
            st_d  = SQ_BYP;
            start = !hit_prot;
          end
          SQ_BEXIT: st_d = SQ_READ;
          default:  st_d = SQ_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_READ;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/dfc_bank.sv
module dfc_bank
  import dfc_pkg::*;
#(
  parameter int NSECT     = 8,
  parameter int SW_BITS   = 2,
  parameter int DW        = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  op_e                         op,
  input  logic [$clog2(NSECT)+SW_BITS-1:0] cell_off,
  input  logic [DW-1:0]               wdata,
  input  logic [NSECT-1:0]            prot,
  output logic                        busy,
  output logic [DW-1:0]               rd_data
);
  localparam int SB   = $clog2(NSECT);
  localparam int NW   = NSECT << SW_BITS;
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC);

  logic [DW-1:0]       mem [NW];
  logic [CW-1:0]       cnt_q;
  op_e                 op_q;
  logic [SB+SW_BITS-1:0] idx_q;
  logic [DW-1:0]       data_q;
  logic [NSECT-1:0]    keep_q;

  assign rd_data = mem[cell_off];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
      idx_q  <= '0;
      data_q <= '0;
      keep_q <= '0;
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      op_q   <= op;
      idx_q  <= cell_off;
      data_q <= wdata;
      keep_q <= prot;
      cnt_q  <= (op == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy <= 1'b0;
        unique case (op_q)
          OP_PROG: mem[idx_q] <= mem[idx_q] & data_q;
          OP_SECT: begin
            for (int w = 0; w < (1 << SW_BITS); w++)
              mem[{idx_q[SW_BITS +: SB], SW_BITS'(w)}] <= '1;
          end
          default: begin
            for (int i = 0; i < NW; i++)
              if (!keep_q[i >> SW_BITS]) mem[i] <= '1;
          end
        endcase
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_flash_ctl.sv
module dual_flash_ctl
  import dfc_pkg::*;
#(
  parameter bit WIDE16     = 1'b0,
  parameter int MAIN_SECT  = 8,
  parameter int AUX_SECT   = 4,
  parameter int SECT_WORDS = 4,
  parameter int OFF_W      = 12,
  parameter int PROG_CYC   = 8,
  parameter int ERASE_CYC  = 32,
  localparam int DW        = WIDE16 ? 16 : 8,
  localparam int NPROT     = MAIN_SECT + AUX_SECT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [OFF_W:0]     req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  input  logic [NPROT-1:0]   prot_mask,
  output logic               rdy,
  output logic               viol
);
  localparam int SW_BITS = $clog2(SECT_WORDS);

  logic [1:0]    busy_v;
  logic [DW-1:0] rd_arr [2];
  logic          sel, rd_go;

  assign req_ready = 1'b1;
  assign sel       = req_addr[OFF_W];
  assign rd_go     = req_valid && !req_write;
  assign rdy       = ~|busy_v;

  for (genvar g = 0; g < 2; g++) begin : g_arr
    localparam int NS   = (g == 0) ? MAIN_SECT : AUX_SECT;
    localparam int BASE = (g == 0) ? 0 : MAIN_SECT;
    localparam int SB   = $clog2(NS);
    logic wr_en, start;
    op_e  op;

    assign wr_en = req_valid && req_write && (sel == 1'(g));

    dfc_seq #(.NSECT(NS), .SW_BITS(SW_BITS), .OFF_W(OFF_W), .DW(DW), .WIDE16(WIDE16)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy_v[g]),
      .off(req_addr[OFF_W-1:0]), .wdata(req_wdata), .prot(prot_mask[BASE +: NS]),
      .start(start), .op(op)
    );

    dfc_bank #(.NSECT(NS), .SW_BITS(SW_BITS), .DW(DW),
               .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .cell_off(req_addr[SB+SW_BITS-1:0]), .wdata(req_wdata),
      .prot(prot_mask[BASE +: NS]), .busy(busy_v[g]), .rd_data(rd_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      viol      <= 1'b0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= busy_v[sel] ? DW'(K_STATUS) : rd_arr[sel];
      if (rd_go && busy_v[sel]) viol <= 1'b1;
    end
  end

endmodule

// File: rtl/dfc_chk.sv
module dfc_chk #(
  parameter int OFF_W = 12,
  parameter int DW    = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [OFF_W:0] req_addr,
  input logic           rsp_valid,
  input logic [DW-1:0]  rsp_data,
  input logic           rdy,
  input logic           viol,
  input logic [1:0]     busy_v
);
  logic rd_go;
  assign rd_go = req_valid && !req_write;

  a_r10_status_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && busy_v[req_addr[OFF_W]]) |=> (rsp_data == DW'(8'h08) && viol));

  a_r10_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

  a_r13_rsp_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);

  a_r13_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rsp_valid);

  a_r4_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(req_valid && req_write));

  a_r11_main_own_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_v[0]) |-> $past(req_valid && req_write && !req_addr[OFF_W]));

  a_r11_aux_own_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_v[1]) |-> $past(req_valid && req_write && req_addr[OFF_W]));

endmodule

bind dual_flash_ctl dfc_chk #(.OFF_W(OFF_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rdy(rdy), .viol(viol), .busy_v(busy_v)
);

// File: tb/dual_flash_ctl_tb_top.sv
module dual_flash_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m16 = 1'b0;
  logic        v = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [15:0] wd = '0;
  logic [11:0] prot = '0;

  logic        rq8, rv8, rdy8, viol8, rq16, rv16, rdy16, viol16;
  logic [7:0]  rd8;
  logic [15:0] rd16;
  logic        cur_rdy, cur_rv, cur_viol;
  logic [15:0] cur_data;

  int n_tests = 0, n_fail = 0;
  logic [15:0] rdat;
  logic        rvld;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dual_flash_ctl #(.WIDE16(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v && !m16), .req_ready(rq8), .req_write(wr),
    .req_addr(addr), .req_wdata(wd[7:0]), .rsp_valid(rv8), .rsp_data(rd8),
    .prot_mask(prot), .rdy(rdy8), .viol(viol8));

  dual_flash_ctl #(.WIDE16(1'b1)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v && m16), .req_ready(rq16), .req_write(wr),
    .req_addr(addr), .req_wdata(wd), .rsp_valid(rv16), .rsp_data(rd16),
    .prot_mask(prot), .rdy(rdy16), .viol(viol16));

  assign cur_rdy  = m16 ? rdy16 : rdy8;
  assign cur_rv   = m16 ? rv16 : rv8;
  assign cur_viol = m16 ? viol16 : viol8;
  assign cur_data = m16 ? rd16 : {8'h00, rd8};

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] ofs_a();
    return m16 ? 12'h555 : 12'hAAA;
  endfunction
  function automatic logic [11:0] ofs_b();
    return m16 ? 12'h2AA : 12'h555;
  endfunction

  task automatic wr_cyc(input logic a, input logic [11:0] o, input logic [15:0] d);
    @(negedge clk); v = 1'b1; wr = 1'b1; addr = {a, o}; wd = d;
    @(negedge clk); v = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_cyc(input logic a, input logic [11:0] o);
    @(negedge clk); v = 1'b1; wr = 1'b0; addr = {a, o};
    @(negedge clk); rvld = cur_rv; rdat = cur_data; v = 1'b0;
  endtask

  task automatic unlock(input logic a);
    wr_cyc(a, ofs_a(), 16'h00AA);
    wr_cyc(a, ofs_b(), 16'h0055);
  endtask

  task automatic prog(input logic a, input logic [11:0] o, input logic [15:0] d);
    unlock(a);
    wr_cyc(a, ofs_a(), 16'h00A0);
    wr_cyc(a, o, d);
  endtask

  task automatic erase_pre(input logic a);
    unlock(a);
    wr_cyc(a, ofs_a(), 16'h0080);
    unlock(a);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!cur_rdy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) ^ 8'hC3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdy", {15'd0, rdy8}, 16'd1);
    chk("R1 viol", {15'd0, viol8}, 16'd0);
    chk("R1 rsp_valid", {15'd0, rv8}, 16'd0);
    chk("R13 req_ready", {15'd0, rq8}, 16'd1);
    rd_cyc(1'b0, 12'h000);
    chk("R1 erased cell", rdat, 16'h00FF);
    chk("R13 rsp_valid on read", {15'd0, rvld}, 16'd1);

    // R2 sweep: program every secondary cell and read all back
    for (int i = 0; i < 16; i++) begin
      prog(1'b1, 12'(i), {8'h00, pat(i)});
      wait_rdy(n);
    end
    for (int i = 0; i < 16; i++) begin
      rd_cyc(1'b1, 12'(i));
      chk("R2 sweep secondary", rdat, {8'h00, pat(i)});
    end

    // R2 / R4 program main sector 2 word 1
    prog(1'b0, 12'h009, 16'h00A5);
    chk("R13 no rsp after write", {15'd0, cur_rv}, 16'd0);
    wait_rdy(n);
    chk("R4 program busy cycles", 16'(n), 16'd8);
    rd_cyc(1'b0, 12'h009);
    chk("R2 program readback", rdat, 16'h00A5);

    // R3 bits only cleared
    prog(1'b0, 12'h009, 16'h005A);
    wait_rdy(n);
    rd_cyc(1'b0, 12'h009);
    chk("R3 and of old and new", rdat, 16'h0000);
    prog(1'b0, 12'h00C, 16'h003C);
    wait_rdy(n);

    // R5 sector erase of sector 2
    erase_pre(1'b0);
    wr_cyc(1'b0, 12'h008, 16'h0030);
    wait_rdy(n);
    chk("R4 erase busy cycles", 16'(n), 16'd32);
    rd_cyc(1'b0, 12'h009);
    chk("R5 erased sector", rdat, 16'h00FF);
    rd_cyc(1'b0, 12'h00C);
    chk("R5 other sector kept", rdat, 16'h003C);

    // R7 protected sector 4
    prot = 12'h010;
    prog(1'b0, 12'h010, 16'h0011);
    chk("R7 refused stays ready", {15'd0, cur_rdy}, 16'd1);
    rd_cyc(1'b0, 12'h010);
    chk("R7 protected unchanged", rdat, 16'h00FF);
    prot = '0;

    // R8 broken sequence and reset command
    wr_cyc(1'b0, ofs_a(), 16'h00AA);
    wr_cyc(1'b0, ofs_b(), 16'h0056);
    wr_cyc(1'b0, ofs_a(), 16'h00A0);
    wr_cyc(1'b0, 12'h011, 16'h0022);
    chk("R8 bad seq no busy", {15'd0, cur_rdy}, 16'd1);
    rd_cyc(1'b0, 12'h011);
    chk("R8 bad seq no program", rdat, 16'h00FF);
    unlock(1'b0);
    wr_cyc(1'b0, 12'h123, 16'h00F0);
    wr_cyc(1'b0, ofs_a(), 16'h00A0);
    wr_cyc(1'b0, 12'h011, 16'h0022);
    rd_cyc(1'b0, 12'h011);
    chk("R8 reset cmd aborts", rdat, 16'h00FF);

    // R6 bulk erase with sector 3 protected
    prog(1'b0, 12'h014, 16'h0077);
    wait_rdy(n);
    prot = 12'h008;
    erase_pre(1'b0);
    wr_cyc(1'b0, ofs_a(), 16'h0010);
    wait_rdy(n);
    chk("R6 bulk busy cycles", 16'(n), 16'd32);
    prot = '0;
    rd_cyc(1'b0, 12'h014);
    chk("R6 bulk erased", rdat, 16'h00FF);
    rd_cyc(1'b0, 12'h00C);
    chk("R7 bulk spares protected", rdat, 16'h003C);

    // R9 bypass mode
    unlock(1'b0);
    wr_cyc(1'b0, ofs_a(), 16'h0020);
    wr_cyc(1'b0, 12'h018, 16'h00A0);
    wr_cyc(1'b0, 12'h018, 16'h0066);
    wait_rdy(n);
    chk("R9 bypass busy cycles", 16'(n), 16'd8);
    rd_cyc(1'b0, 12'h018);
    chk("R9 bypass program 1", rdat, 16'h0066);
    wr_cyc(1'b0, 12'h019, 16'h00A0);
    wr_cyc(1'b0, 12'h019, 16'h0044);
    wait_rdy(n);
    rd_cyc(1'b0, 12'h019);
    chk("R9 bypass program 2", rdat, 16'h0044);
    wr_cyc(1'b0, 12'h000, 16'h0090);
    wr_cyc(1'b0, 12'h000, 16'h0000);
    wr_cyc(1'b0, 12'h01A, 16'h00A0);
    wr_cyc(1'b0, 12'h01A, 16'h0012);
    rd_cyc(1'b0, 12'h01A);
    chk("R9 after exit no program", rdat, 16'h00FF);
    unlock(1'b0);
    wr_cyc(1'b0, ofs_a(), 16'h0020);
    wr_cyc(1'b0, 12'h000, 16'h00F0);
    wr_cyc(1'b0, 12'h01B, 16'h00A0);
    wr_cyc(1'b0, 12'h01B, 16'h0012);
    rd_cyc(1'b0, 12'h01B);
    chk("R8 reset cmd exits bypass", rdat, 16'h00FF);

    // R10 / R11 busy read and independence
    prog(1'b1, 12'h000, 16'h00FF);
    rd_cyc(1'b1, 12'h000);
    chk("R10 status valid", {15'd0, rvld}, 16'd1);
    chk("R10 status word", rdat, 16'h0008);
    chk("R10 viol set", {15'd0, cur_viol}, 16'd1);
    rd_cyc(1'b0, 12'h018);
    chk("R11 other array data", rdat, 16'h0066);
    chk("R4 still busy", {15'd0, cur_rdy}, 16'd0);
    wait_rdy(n);
    rd_cyc(1'b1, 12'h000);
    chk("R10 data after busy", rdat, {8'h00, pat(0)});
    chk("R10 viol sticky", {15'd0, cur_viol}, 16'd1);

    // R12 16-bit configuration
    m16 = 1'b1;
    rd_cyc(1'b0, 12'h005);
    chk("R1 16-bit erased", rdat, 16'hFFFF);
    prog(1'b0, 12'h005, 16'h1234);
    wait_rdy(n);
    chk("R12 program busy cycles", 16'(n), 16'd8);
    rd_cyc(1'b0, 12'h005);
    chk("R12 16-bit program", rdat, 16'h1234);
    wr_cyc(1'b0, 12'hAAA, 16'h00AA);
    wr_cyc(1'b0, 12'h555, 16'h0055);
    wr_cyc(1'b0, 12'hAAA, 16'h00A0);
    wr_cyc(1'b0, 12'h006, 16'h0BCD);
    rd_cyc(1'b0, 12'h006);
    chk("R12 8-bit offsets rejected", rdat, 16'hFFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule